// File: doc/BRIEF.md
# Banked Nibble Accumulator CPU Core

A compact 4-bit processor core with two working registers, a carry flag, a 4-bit program counter, a 4-bit input port and a latched 4-bit output port. Every instruction is one byte: an opcode nibble in bits 7:4 and an immediate nibble in bits 3:0. Each instruction completes in a single clock. Twelve opcodes form a fixed legacy set of moves, adds, port transfers and jumps. Programs written for that set run unchanged.

The remaining four opcodes extend the machine. Two of them load and store register B in a banked data memory. The other two select the data bank and the program bank. The program store and the data memory are plain arrays held inside the top level. A write port fills the program store before the core is released from reset. A fetch reads the program store at the program-bank number concatenated with the program counter.

Top module: `nib4_core`

## Requirements
- R1: A synchronous reset clears A, B, the output port, the program counter, the carry flag, the output strobe and both bank registers. Neither array is cleared.
- R2: Each instruction completes in one clock. The program counter advances by one, modulo 16, unless a jump is taken.
- R3: The register transfers compute source + immediate, modulo 16. The opcodes are: 0x0 A=A+imm, 0x1 A=B+imm, 0x2 A=in_port+imm, 0x3 A=imm, 0x4 B=A+imm, 0x5 B=B+imm, 0x6 B=in_port+imm, 0x7 B=imm.
- R4: For the twelve legacy opcodes, the carry flag takes the carry-out of that instruction's 4-bit sum. Immediate-only forms can never carry. Opcodes 0x8, 0xA, 0xC and 0xD always clear the carry flag.
- R5: Opcode 0xE jumps to the immediate only when the carry flag is clear, and otherwise falls through. Opcode 0xF always jumps to the immediate.
- R6: Opcode 0x9 drives B+imm onto out_port. Opcode 0xB drives the immediate onto out_port. out_valid is high for exactly the one cycle after each of these two opcodes, and low after every other opcode.
- R7: Opcode 0x8 loads B from data memory at {data bank, imm}.
- R8: Opcode 0xA writes B into data memory at {data bank, imm}. Locations in other banks keep their contents.
- R9: Opcode 0xC loads the immediate into the data bank register. Later loads and stores use the new bank.
- R10: Opcode 0xD loads the immediate into the program bank register. The next fetch reads {new bank, pc+1}. Reset returns fetching to bank 0.
- R11: The program 0x40, 0x90, 0x11, 0xE0, 0xF4 outputs 0 through 15 in order, then falls through into the self-jump at address 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | ROM_BANK_W+4 | Program store write address {bank, word} |
| prog_data | input | 8 | Program word to write |
| in_port | input | 4 | Input port |
| out_port | output | 4 | Latched output port |
| out_valid | output | 1 | One-cycle strobe following an output instruction |
| pc_o | output | 4 | Program counter |
| carry_o | output | 1 | Carry flag |

## Verification
The bench builds the core with its default widths: 4-bit program and data bank registers, so sixteen program banks and sixteen data banks of sixteen words each. With these widths, the same data address can be written in banks 0 and 2 and read back to show that the banks are separate. A bank-select can also hop execution from bank 0 into bank 1 part way through a program. A scoreboard holds the expected output sequence for each program, covering arithmetic wrap, both outcomes of the conditional jump, and memory round trips. A reset while bank 1 is active then shows that fetching restarts in bank 0.

// File: rtl/nib4_pkg.sv
package nib4_pkg;
    localparam int NIB_W   = 4;
    localparam int OP_W    = 4;
    localparam int INSTR_W = OP_W + NIB_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_A  = 4'h0,
        OP_MOV_AB = 4'h1,
        OP_IN_A   = 4'h2,
        OP_MOV_AI = 4'h3,
        OP_MOV_BA = 4'h4,
        OP_ADD_B  = 4'h5,
        OP_IN_B   = 4'h6,
        OP_MOV_BI = 4'h7,
        OP_LOAD   = 4'h8,
        OP_OUT_B  = 4'h9,
        OP_STORE  = 4'hA,
        OP_OUT_I  = 4'hB,
        OP_DBANK  = 4'hC,
        OP_PBANK  = 4'hD,
        OP_JNC    = 4'hE,
        OP_JMP    = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {SRC_ZERO, SRC_A, SRC_B, SRC_IN} src_e;
    typedef enum logic [2:0] {DST_NONE, DST_A, DST_B, DST_OUT, DST_PC} dst_e;

    typedef struct packed {
        src_e src;
        dst_e dst;
        logic legacy;
        logic cond;
        logic load;
        logic store;
        logic dbank;
        logic pbank;
    } ctrl_t;
endpackage

// File: rtl/nib4_decode.sv
module nib4_decode
    import nib4_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctrl_t           ctrl
);
    always_comb begin
        ctrl = '{src: SRC_ZERO, dst: DST_NONE, legacy: 1'b1, cond: 1'b0,
                 load: 1'b0, store: 1'b0, dbank: 1'b0, pbank: 1'b0};
        case (op)
            OP_ADD_A:  begin ctrl.src = SRC_A;    ctrl.dst = DST_A;   end
            OP_MOV_AB: begin ctrl.src = SRC_B;    ctrl.dst = DST_A;   end
            OP_IN_A:   begin ctrl.src = SRC_IN;   ctrl.dst = DST_A;   end
            OP_MOV_AI: begin ctrl.src = SRC_ZERO; ctrl.dst = DST_A;   end
            OP_MOV_BA: begin ctrl.src = SRC_A;    ctrl.dst = DST_B;   end
            OP_ADD_B:  begin ctrl.src = SRC_B;    ctrl.dst = DST_B;   end
            OP_IN_B:   begin ctrl.src = SRC_IN;   ctrl.dst = DST_B;   end
            OP_MOV_BI: begin ctrl.src = SRC_ZERO; ctrl.dst = DST_B;   end
            OP_OUT_B:  begin ctrl.src = SRC_B;    ctrl.dst = DST_OUT; end
            OP_OUT_I:  begin ctrl.src = SRC_ZERO; ctrl.dst = DST_OUT; end
            OP_JNC:    begin ctrl.dst = DST_PC;   ctrl.cond = 1'b1;   end
            OP_JMP:    begin ctrl.dst = DST_PC;                       end
            OP_LOAD:   begin ctrl.legacy = 1'b0;  ctrl.load  = 1'b1;  end
            OP_STORE:  begin ctrl.legacy = 1'b0;  ctrl.store = 1'b1;  end
            OP_DBANK:  begin ctrl.legacy = 1'b0;  ctrl.dbank = 1'b1;  end
            OP_PBANK:  begin ctrl.legacy = 1'b0;  ctrl.pbank = 1'b1;  end
            default:   begin ctrl.dst = DST_NONE;                     end
        endcase
    end
endmodule

// File: rtl/nib4_adder.sv
module nib4_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = x[i] ^ y[i] ^ c[i];
        assign c[i+1]  = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign co = c[W];
endmodule

// File: rtl/nib4_mem.sv
module nib4_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nib4_core.sv
module nib4_core
    import nib4_pkg::*;
#(
    parameter int ROM_BANK_W = 4,
    parameter int RAM_BANK_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      prog_we,
    input  logic [ROM_BANK_W+NIB_W-1:0] prog_addr,
    input  logic [INSTR_W-1:0]        prog_data,
    input  logic [NIB_W-1:0]          in_port,
    output logic [NIB_W-1:0]          out_port,
    output logic                      out_valid,
    output logic [NIB_W-1:0]          pc_o,
    output logic                      carry_o
);
    localparam int ROM_AW = ROM_BANK_W + NIB_W;
    localparam int RAM_AW = RAM_BANK_W + NIB_W;

    typedef struct packed {
        logic [NIB_W-1:0]      a;
        logic [NIB_W-1:0]      b;
        logic [NIB_W-1:0]      outp;
        logic [NIB_W-1:0]      pc;
        logic                  carry;
        logic                  outv;
        logic [ROM_BANK_W-1:0] pbank;
        logic [RAM_BANK_W-1:0] dbank;
    } state_t;

    state_t st_d, st_q;

    logic [INSTR_W-1:0] instr_w;
    logic [NIB_W-1:0]   imm;
    ctrl_t              ctrl;
    logic [NIB_W-1:0]   src_val;
    logic [NIB_W-1:0]   sum;
    logic               sum_co;
    logic [NIB_W-1:0]   ram_rdata;
    logic               ram_we;

    nib4_mem #(.AW(ROM_AW), .DW(INSTR_W)) u_prog (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr ({st_q.pbank, st_q.pc}),
        .rdata (instr_w)
    );

    assign imm = instr_w[NIB_W-1:0];

    nib4_decode u_dec (
        .op   (instr_w[INSTR_W-1:NIB_W]),
        .ctrl (ctrl)
    );

    always_comb begin
        case (ctrl.src)
            SRC_A:   src_val = st_q.a;
            SRC_B:   src_val = st_q.b;
            SRC_IN:  src_val = in_port;
            default: src_val = '0;
        endcase
    end

    nib4_adder #(.W(NIB_W)) u_add (
        .x   (src_val),
        .y   (imm),
        .sum (sum),
        .co  (sum_co)
    );

    assign ram_we = ctrl.store & ~rst;

    nib4_mem #(.AW(RAM_AW), .DW(NIB_W)) u_data (
        .clk   (clk),
        .we    (ram_we),
        .waddr ({st_q.dbank, imm}),
        .wdata (st_q.b),
        .raddr ({st_q.dbank, imm}),
        .rdata (ram_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pc    = st_q.pc + 1'b1;
        st_d.outv  = 1'b0;
        st_d.carry = ctrl.legacy & sum_co;
        case (ctrl.dst)
            DST_A:   st_d.a = sum;
            DST_B:   st_d.b = sum;
            DST_OUT: begin
                st_d.outp = sum;
                st_d.outv = 1'b1;
            end
            DST_PC:  begin
                if (!ctrl.cond || !st_q.carry) st_d.pc = sum;
            end
            default: ;
        endcase
        if (ctrl.load)  st_d.b     = ram_rdata;
        if (ctrl.dbank) st_d.dbank = RAM_BANK_W'(imm);
        if (ctrl.pbank) st_d.pbank = ROM_BANK_W'(imm);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_port  = st_q.outp;
    assign out_valid = st_q.outv;
    assign pc_o      = st_q.pc;
    assign carry_o   = st_q.carry;
endmodule

// File: rtl/nib4_core_chk.sv
module nib4_core_chk
    import nib4_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr,
    input logic [NIB_W-1:0]   pc_o,
    input logic               carry_o,
    input logic [NIB_W-1:0]   out_port,
    input logic               out_valid
);
    logic [OP_W-1:0]  op;
    logic [NIB_W-1:0] im;
    logic             is_jump, is_ext, is_out;

    assign op      = instr[INSTR_W-1:NIB_W];
    assign im      = instr[NIB_W-1:0];
    assign is_jump = (op == OP_JMP) || (op == OP_JNC);
    assign is_ext  = (op == OP_LOAD) || (op == OP_STORE) || (op == OP_DBANK) || (op == OP_PBANK);
    assign is_out  = (op == OP_OUT_B) || (op == OP_OUT_I);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (pc_o == '0 && carry_o == 1'b0 && out_port == '0 && out_valid == 1'b0));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !is_jump |=> pc_o == NIB_W'($past(pc_o) + 1'b1));

    assert_ext_clears_carry_R4: assert property (@(posedge clk) disable iff (rst)
        is_ext |=> !carry_o);

    assert_jmp_target_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JMP) |=> pc_o == $past(im));

    assert_jnc_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JNC && !carry_o) |=> pc_o == $past(im));

    assert_jnc_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JNC && carry_o) |=> pc_o == NIB_W'($past(pc_o) + 1'b1));

    assert_out_imm_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_OUT_I) |=> (out_valid && out_port == $past(im)));

    assert_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !is_out |=> !out_valid);
endmodule

bind nib4_core nib4_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr_w),
    .pc_o      (pc_o),
    .carry_o   (carry_o),
    .out_port  (out_port),
    .out_valid (out_valid)
);

// File: tb/sim_nib4_core.sv
`timescale 1ns/1ps
module sim_nib4_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [7:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [3:0] in_port = '0;
    logic [3:0] out_port;
    logic       out_valid;
    logic [3:0] pc_o;
    logic       carry_o;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R6";
    logic [3:0] exp_q[$];

    always #2.5 clk = ~clk;

    nib4_core u0 (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .in_port(in_port), .out_port(out_port),
        .out_valid(out_valid), .pc_o(pc_o), .carry_o(carry_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int bank, input int addr, input logic [7:0] w);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_addr = 8'((bank << 4) | addr);
        prog_data = w;
        @(negedge clk);
        prog_we   = 1'b0;
    endtask

    task automatic push_exp(input logic [3:0] v);
        exp_q.push_back(v);
    endtask

    task automatic run(input int cycles);
        @(negedge clk);
        rst = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected output"}, out_port, 0);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check(out_port == e, {cur_req, " output value"}, out_port, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pc_o == 0 && carry_o == 0 && out_port == 0 && out_valid == 0,
              "R1 reset state", {pc_o, out_port}, 0);

        // R11 counting program, also R2 single-cycle stepping
        put(0, 0, 8'h40);
        put(0, 1, 8'h90);
        put(0, 2, 8'h11);
        put(0, 3, 8'hE0);
        put(0, 4, 8'hF4);
        cur_req = "R11";
        for (int i = 0; i < 16; i++) push_exp(4'(i));
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pc_o == 1, "R2 pc after first instruction", pc_o, 1);
        @(negedge clk);
        check(out_valid == 1 && pc_o == 2, "R2 output one cycle later", {out_valid, pc_o}, 8'h12);
        repeat (70) @(negedge clk);
        check(exp_q.size() == 0, "R11 all 16 values seen", exp_q.size(), 0);
        check(pc_o == 4, "R11 fell through to halt", pc_o, 4);
        check(carry_o == 0, "R4 jump leaves carry clear", carry_o, 0);

        // R3/R4/R5/R6 arithmetic program
        hold_reset();
        in_port = 4'h5;
        put(0, 4'h0, 8'h39);  // A=9
        put(0, 4'h1, 8'h09);  // A=2, carry
        put(0, 4'h2, 8'hE6);  // JNC not taken
        put(0, 4'h3, 8'h40);  // B=2, carry clear
        put(0, 4'h4, 8'h90);  // out 2
        put(0, 4'h5, 8'hE7);  // JNC taken
        put(0, 4'h6, 8'hBF);  // skipped
        put(0, 4'h7, 8'h63);  // B=in+3=8
        put(0, 4'h8, 8'h90);  // out 8
        put(0, 4'h9, 8'h20);  // A=in=5
        put(0, 4'hA, 8'h5F);  // B=7 carry
        put(0, 4'hB, 8'h91);  // out 8
        put(0, 4'hC, 8'h04);  // A=9
        put(0, 4'hD, 8'h40);  // B=9
        put(0, 4'hE, 8'h94);  // out D
        put(0, 4'hF, 8'hFF);  // halt
        cur_req = "R3";
        push_exp(4'h2); push_exp(4'h8); push_exp(4'h8); push_exp(4'hD);
        run(25);
        check(exp_q.size() == 0, "R5 JNC skip/take sequence", exp_q.size(), 0);
        check(pc_o == 4'hF, "R5 JMP halt address", pc_o, 15);
        check(carry_o == 0, "R4 carry after halt", carry_o, 0);

        // R7-R10 memory and bank program
        hold_reset();
        put(0, 4'h0, 8'h76);  // B=6
        put(0, 4'h1, 8'hA3);  // store bank0[3]=6
        put(0, 4'h2, 8'hC2);  // data bank 2
        put(0, 4'h3, 8'h7A);  // B=A
        put(0, 4'h4, 8'hA3);  // store bank2[3]=A
        put(0, 4'h5, 8'h83);  // load -> A
        put(0, 4'h6, 8'h90);  // out A
        put(0, 4'h7, 8'hC0);  // data bank 0
        put(0, 4'h8, 8'h83);  // load -> 6
        put(0, 4'h9, 8'h90);  // out 6
        put(0, 4'hA, 8'h7F);  // B=F
        put(0, 4'hB, 8'h51);  // B=0 carry
        put(0, 4'hC, 8'hD1);  // program bank 1, carry clears
        put(1, 4'hD, 8'hE0);  // JNC taken -> bank1 addr0
        put(1, 4'h0, 8'hB5);  // out 5
        put(1, 4'h1, 8'hC2);  // data bank 2
        put(1, 4'h2, 8'h83);  // load -> A
        put(1, 4'h3, 8'h90);  // out A
        put(1, 4'h4, 8'hF4);  // halt
        cur_req = "R8";
        push_exp(4'hA); push_exp(4'h6); push_exp(4'h5); push_exp(4'hA);
        run(30);
        check(exp_q.size() == 0, "R9 R10 bank sequence complete", exp_q.size(), 0);
        check(pc_o == 4, "R10 halted in bank 1", pc_o, 4);

        // R1/R10: reset returns fetch to bank 0
        hold_reset();
        check(pc_o == 0 && carry_o == 0 && out_port == 0 && out_valid == 0,
              "R1 reset after run", {pc_o, out_port}, 0);
        cur_req = "R10";
        push_exp(4'hA); push_exp(4'h6); push_exp(4'h5); push_exp(4'hA);
        run(30);
        check(exp_q.size() == 0, "R10 restart from bank 0", exp_q.size(), 0);
        check(pc_o == 4, "R7 rerun halt", pc_o, 4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule